// File: doc/BRIEF.md
# Deadzone Counter Duty Controller

This block closes the digital feedback loop of a boost switching converter. A window comparator outside the block reports the output voltage as two one-bit flags: one asserted when the output has fallen under the lower edge of a deadzone window, the other asserted when it has risen over the upper edge. The block's only control law is a saturating up/down counter that holds the duty command. When the output is low, the counter steps up. When it is high, the counter steps down. Inside the window it holds, so the loop settles without a limit cycle.

A counter-compare PWM turns the duty command into the gate drive for the power switch. The PWM period is a power-of-two number of clocks. The duty command moves only at the end of a PWM period. Each switching cycle therefore uses a single, constant on-time. Both comparator flags are synchronised before they are used. If both flags are asserted together, the condition is taken as a sensor fault and the duty is frozen.

Top module: `dz_duty_ctrl`

## Requirements
- R1: While reset is asserted, `duty_o` equals DUTY_INIT and `gate_o` is low.
- R2: In every PWM period of 2^PWM_BITS clocks, `gate_o` is high for exactly the first D clocks of the period and low for the rest, where D is the duty value that holds during that period.
- R3: If only `below_i` is seen at a period end, the duty rises by DUTY_STEP.
- R4: If only `above_i` is seen at a period end, the duty falls by DUTY_STEP.
- R5: If neither flag is seen at a period end, the duty is held (deadzone).
- R6: If both flags are seen at a period end, the duty is held (fault).
- R7: The duty saturates at DUTY_MAX when rising and at DUTY_MIN when falling, and never wraps.
- R8: `duty_o` changes only on the clock edge that closes a PWM period.
- R9: Each flag passes through two synchroniser flops. A period-end update uses the flag level sampled on the rising edge two clocks before the closing edge. A flag change made after that edge takes effect one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| below_i | input | 1 | Comparator flag: output under the lower window edge (asynchronous) |
| above_i | input | 1 | Comparator flag: output over the upper window edge (asynchronous) |
| gate_o | output | 1 | PWM gate drive for the power switch |
| duty_o | output | PWM_BITS | Current duty command in clocks per period |

## Verification
The hardest case to reach from the ports is the synchroniser boundary. A flag change that lands one clock too late for a period end must be deferred by a whole period. The stimulus moves a flag at a chosen phase of the period: one clock before the sampling edge, and on the edge itself. It then checks that the duty in the following period reflects the old flag level or the new one, as the timing requires. Saturation at both limits is reached by holding one flag for more periods than the range needs, and the fault freeze is reached by asserting both flags together.

// File: rtl/dzc_pkg.sv
package dzc_pkg;
   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_RAISE = 2'd1,
      CMD_LOWER = 2'd2,
      CMD_FAULT = 2'd3
   } dz_cmd_e;
endpackage

// File: rtl/dzc_sync.sv
module dzc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= 1'b0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dzc_decide.sv
module dzc_decide
   import dzc_pkg::*;
(
   input  logic    low_s,
   input  logic    high_s,
   output dz_cmd_e cmd
);
   always_comb begin
      unique case ({high_s, low_s})
         2'b01:   cmd = CMD_RAISE;
         2'b10:   cmd = CMD_LOWER;
         2'b11:   cmd = CMD_FAULT;
         default: cmd = CMD_HOLD;
      endcase
   end
endmodule

// File: rtl/dzc_duty_acc.sv
module dzc_duty_acc
   import dzc_pkg::*;
#(
   parameter int DW       = 6,
   parameter int MIN_VAL  = 4,
   parameter int MAX_VAL  = 40,
   parameter int INIT_VAL = 20,
   parameter int STEP     = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  dz_cmd_e       cmd,
   output logic [DW-1:0] duty
);
   localparam logic [DW:0]   STEP_W = (DW+1)'(STEP);
   localparam logic [DW:0]   MAX_W  = (DW+1)'(MAX_VAL);
   localparam logic [DW:0]   LOW_W  = (DW+1)'(MIN_VAL + STEP);
   localparam logic [DW-1:0] MIN_D  = DW'(MIN_VAL);
   localparam logic [DW-1:0] MAX_D  = DW'(MAX_VAL);
   localparam logic [DW-1:0] INIT_D = DW'(INIT_VAL);

   logic [DW:0]   up_sum;
   logic [DW-1:0] up_sat;
   logic [DW-1:0] dn_sat;
   logic [DW-1:0] duty_nxt;

   assign up_sum = {1'b0, duty} + STEP_W;
   assign up_sat = (up_sum > MAX_W) ? MAX_D : up_sum[DW-1:0];
   assign dn_sat = ({1'b0, duty} < LOW_W) ? MIN_D : (duty - STEP_W[DW-1:0]);

   always_comb begin
      duty_nxt = duty;
      if (tick) begin
         unique case (cmd)
            CMD_RAISE: duty_nxt = up_sat;
            CMD_LOWER: duty_nxt = dn_sat;
            default:   duty_nxt = duty;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) duty <= INIT_D;
      else     duty <= duty_nxt;
   end
endmodule

// File: rtl/dzc_pwm.sv
module dzc_pwm #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] duty,
   output logic         gate,
   output logic         period_end
);
   logic [N-1:0] pcnt;

   assign period_end = &pcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt <= '0;
         gate <= 1'b0;
      end else begin
         pcnt <= pcnt + 1'b1;
         gate <= (pcnt < duty);
      end
   end
endmodule

// File: rtl/dz_duty_ctrl.sv
module dz_duty_ctrl
   import dzc_pkg::*;
#(
   parameter int PWM_BITS    = 6,
   parameter int DUTY_MIN    = 4,
   parameter int DUTY_MAX    = 40,
   parameter int DUTY_INIT   = 20,
   parameter int DUTY_STEP   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                below_i,
   input  logic                above_i,
   output logic                gate_o,
   output logic [PWM_BITS-1:0] duty_o
);
   localparam int PERIOD = 1 << PWM_BITS;

   initial begin
      assert (PWM_BITS >= 2 && PWM_BITS <= 16) else $error("PWM_BITS out of range");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DUTY_MIN <= DUTY_MAX) else $error("DUTY_MIN above DUTY_MAX");
      assert (DUTY_MAX < PERIOD) else $error("DUTY_MAX does not fit the period");
      assert (DUTY_INIT >= DUTY_MIN && DUTY_INIT <= DUTY_MAX) else $error("DUTY_INIT outside limits");
      assert (DUTY_STEP >= 1 && DUTY_STEP < PERIOD) else $error("DUTY_STEP out of range");
   end

   logic    low_s;
   logic    high_s;
   dz_cmd_e cmd;
   logic    period_end;

   dzc_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
      .clk(clk), .rst(rst), .d(below_i), .q(low_s)
   );

   dzc_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
      .clk(clk), .rst(rst), .d(above_i), .q(high_s)
   );

   dzc_decide u_decide (
      .low_s(low_s), .high_s(high_s), .cmd(cmd)
   );

   dzc_duty_acc #(
      .DW(PWM_BITS), .MIN_VAL(DUTY_MIN), .MAX_VAL(DUTY_MAX),
      .INIT_VAL(DUTY_INIT), .STEP(DUTY_STEP)
   ) u_acc (
      .clk(clk), .rst(rst), .tick(period_end), .cmd(cmd), .duty(duty_o)
   );

   dzc_pwm #(.N(PWM_BITS)) u_pwm (
      .clk(clk), .rst(rst), .duty(duty_o), .gate(gate_o), .period_end(period_end)
   );
endmodule

// File: rtl/dzc_chk.sv
module dzc_chk
   import dzc_pkg::*;
#(
   parameter int DW       = 6,
   parameter int MIN_VAL  = 4,
   parameter int MAX_VAL  = 40,
   parameter int INIT_VAL = 20,
   parameter int STEP     = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          tick,
   input dz_cmd_e       cmd,
   input logic [DW-1:0] duty,
   input logic          gate
);
   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   // R1: one edge after reset is sampled, the outputs hold their reset values
   always @(posedge clk) begin
      if (rst_seen && rst) begin
         a_r1_reset_state: assert (duty == DW'(INIT_VAL) && !gate);
      end
   end

   a_r7_within_limits: assert property (@(posedge clk) disable iff (rst)
      (int'(duty) >= MIN_VAL && int'(duty) <= MAX_VAL));

   a_r8_change_only_at_end: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(duty));

   a_r5_deadzone_hold: assert property (@(posedge clk) disable iff (rst)
      (tick && cmd == CMD_HOLD) |=> $stable(duty));

   a_r6_fault_hold: assert property (@(posedge clk) disable iff (rst)
      (tick && cmd == CMD_FAULT) |=> $stable(duty));

   a_r3_raise_step: assert property (@(posedge clk) disable iff (rst)
      (tick && cmd == CMD_RAISE && int'(duty) + STEP <= MAX_VAL)
      |=> (int'(duty) == int'($past(duty)) + STEP));

   a_r4_lower_step: assert property (@(posedge clk) disable iff (rst)
      (tick && cmd == CMD_LOWER && int'(duty) - STEP >= MIN_VAL)
      |=> (int'(duty) == int'($past(duty)) - STEP));
endmodule

bind dz_duty_ctrl dzc_chk #(
   .DW(PWM_BITS), .MIN_VAL(DUTY_MIN), .MAX_VAL(DUTY_MAX),
   .INIT_VAL(DUTY_INIT), .STEP(DUTY_STEP)
) u_chk (
   .clk(clk), .rst(rst), .tick(period_end), .cmd(cmd),
   .duty(duty_o), .gate(gate_o)
);

// File: tb/test_dz_duty_ctrl.sv
module test_dz_duty_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 6;
   localparam int PER  = 1 << N;
   localparam int MINV = 4;
   localparam int MAXV = 40;
   localparam int INIT = 20;
   localparam int STEP = 4;
   localparam int NSTEP = 23;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         below = 1'b0;
   logic         above = 1'b0;
   logic         gate;
   logic [N-1:0] duty;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   typedef struct { int duty; string tag; } exp_t;
   exp_t sbq[$];

   typedef struct { bit lo; bit hi; int at; string tag; } step_t;
   step_t steps[NSTEP];

   dz_duty_ctrl #(
      .PWM_BITS(N), .DUTY_MIN(MINV), .DUTY_MAX(MAXV),
      .DUTY_INIT(INIT), .DUTY_STEP(STEP), .SYNC_STAGES(2)
   ) i_dz_duty_ctrl (
      .clk(clk), .rst(rst), .below_i(below), .above_i(above),
      .gate_o(gate), .duty_o(duty)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic wait_cyc(input int c);
      @(negedge clk);
      while (cyc != c) @(negedge clk);
   endtask

   function automatic int model(input int d, input bit lo, input bit hi);
      if (lo && !hi) return (d + STEP > MAXV) ? MAXV : d + STEP;
      if (hi && !lo) return (d - STEP < MINV) ? MINV : d - STEP;
      return d;
   endfunction

   // Driver: applies flags at a chosen phase and pushes the expected duty
   initial begin
      int  expd;
      bit  plo, phi, elo, ehi;
      steps[0]  = '{0, 0, 4,  "R5"};
      steps[1]  = '{0, 0, 4,  "R5"};
      steps[2]  = '{1, 0, 4,  "R3"};
      steps[3]  = '{1, 0, 4,  "R3"};
      steps[4]  = '{1, 0, 4,  "R3"};
      steps[5]  = '{1, 0, 4,  "R3"};
      steps[6]  = '{1, 0, 4,  "R3"};
      steps[7]  = '{1, 0, 4,  "R7"};
      steps[8]  = '{1, 1, 4,  "R6"};
      steps[9]  = '{0, 1, 61, "R9"};
      steps[10] = '{0, 0, 62, "R9"};
      steps[11] = '{0, 0, 4,  "R5"};
      steps[12] = '{0, 1, 4,  "R4"};
      steps[13] = '{0, 1, 4,  "R4"};
      steps[14] = '{0, 1, 4,  "R4"};
      steps[15] = '{0, 1, 4,  "R4"};
      steps[16] = '{0, 1, 4,  "R4"};
      steps[17] = '{0, 1, 4,  "R4"};
      steps[18] = '{0, 1, 4,  "R7"};
      steps[19] = '{0, 1, 4,  "R7"};
      steps[20] = '{0, 0, 4,  "R5"};
      steps[21] = '{1, 0, 62, "R9"};
      steps[22] = '{1, 0, 4,  "R3"};

      // R1: reset state, with a flag asserted that must not move the duty
      below = 1'b1;
      repeat (5) @(negedge clk);
      check(duty == N'(INIT), "R1", "duty in reset", int'(duty), INIT);
      check(gate == 1'b0, "R1", "gate in reset", int'(gate), 0);
      below = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      expd = INIT;
      sbq.push_back('{INIT, "R1"});
      plo = 1'b0; phi = 1'b0;
      for (int k = 0; k < NSTEP; k++) begin
         wait_cyc(PER*k + steps[k].at);
         below = steps[k].lo;
         above = steps[k].hi;
         // R9: a change on the negedge after the sampling edge arrives too late
         if (steps[k].at >= PER - 2) begin elo = plo; ehi = phi; end
         else begin elo = steps[k].lo; ehi = steps[k].hi; end
         plo = steps[k].lo; phi = steps[k].hi;
         expd = model(expd, elo, ehi);
         sbq.push_back('{expd, steps[k].tag});
      end
   end

   // Monitor: per period, pops the expected duty and compares duty and gate
   initial begin
      exp_t e;
      bit   dok, gok;
      int   dbad, gbad, gi;
      wait (rst == 1'b0);
      for (int k = 0; k <= NSTEP; k++) begin
         wait_cyc(PER*k + 1);
         if (sbq.size() == 0) begin
            check(1'b0, "R8", "scoreboard empty", 0, 1);
            break;
         end
         e = sbq.pop_front();
         dok = 1'b1; gok = 1'b1; dbad = 0; gbad = 0; gi = 0;
         for (int i = 0; i < PER; i++) begin
            if (i > 0) @(negedge clk);
            if (i < PER - 1 && int'(duty) != e.duty && dok) begin
               dok = 1'b0; dbad = int'(duty);
            end
            if (gate !== (i < e.duty) && gok) begin
               gok = 1'b0; gbad = int'(gate); gi = i;
            end
         end
         // duty must equal the model and stay constant within the period (R8)
         check(dok, e.tag, $sformatf("duty period %0d (R8 stable)", k),
               dok ? e.duty : dbad, e.duty);
         check(gok, "R2", $sformatf("gate period %0d clock %0d", k, gi),
               gbad, (gi < e.duty) ? 1 : 0);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule